// File: doc/BRIEF.md
# Configuration and Status Register Bank

This block is a slave on a plain register bus with an address, a write enable, write data and registered read data. It holds the configuration and status state that a core exposes to software, and it offers two styles of register. A pass-through register is not stored in the bank. A bus write is forwarded to the core as data plus a one-cycle strobe, and a bus read returns whatever value the core presents on its read input.

A managed register is stored inside the bank and is built from three fields: `mode`, `stat` and `cmd`. Each field has its own access policy on the bus side and on the device side. The concatenation `{mode, stat, cmd}` is wider than a bus word, so it is spread over consecutive word addresses. The word that carries the most significant bits sits at the lowest address.

The bus has no handshake. Every cycle is one access, nothing can stall, and read data appears one cycle after the address. The core's field strobes are plain control pins with no back-pressure.

Top module: `reg_bank`

## Requirements
- R1: Out of reset, every stored field is 0, `bus_rdata` is 0 and `raw_wr_stb` is 0.
- R2: A bus write to address 0 drives `raw_wr_stb` high for exactly the next cycle, with `raw_wr_data` equal to the written data's low RAW_W bits. Without such a write, the strobe stays low.
- R3: A read of address 0 returns `raw_rd_val`, zero-extended to the bus width.
- R4: The managed register is `{mode, stat, cmd}`, 12 bits, with `cmd` in bits 2:0. Bit 0 is the least significant bit of the word at address 2. Address 1 holds bits 11:8 in its low four bits, and its upper bits read as 0.
- R5: `mode` is read-write on the bus and read-only for the device. Bus writes update the bits of `mode` that lie in the written word. `mode_q` always shows the stored value.
- R6: `stat` is read-only on the bus, so bus writes leave it unchanged. A high `stat_we` loads `stat_in`.
- R7: `cmd` is write-only on the bus and reads as 0. A bus write to address 2 loads its low 3 bits. `cmd_q` always shows the stored value.
- R8: When `cmd_we` and a bus write to `cmd` fall in the same cycle, `cmd_in` is stored.
- R9: Addresses other than 0, 1 and 2 read as 0, and writes to them change nothing.
- R10: Read data is registered. `bus_rdata` reflects the address and values present in the preceding cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| raw_wr_data | output | RAW_W | Data from a pass-through write |
| raw_wr_stb | output | 1 | One-cycle strobe qualifying raw_wr_data |
| raw_rd_val | input | RAW_W | Read value supplied by the core |
| mode_q | output | MODE_W | Stored mode field |
| stat_in | input | STAT_W | Device value for stat |
| stat_we | input | 1 | Device strobe for stat |
| cmd_q | output | CMD_W | Stored cmd field |
| cmd_in | input | CMD_W | Device value for cmd |
| cmd_we | input | 1 | Device strobe for cmd |

## Verification
The assertions assume that every input is driven to a known value at each clock edge, and that RAW_W does not exceed DATA_W. They also assume the address map stays at its default placement, so that address 0 is the pass-through register. The bench changes inputs only at falling edges, so every value is stable before each rising edge. Its random addresses span the whole address space, including unmapped words, and device strobes are allowed to collide with bus writes.

// File: rtl/rb_pkg.sv
package rb_pkg;
  typedef enum logic [1:0] {ACC_RO, ACC_WO, ACC_RW} acc_e;
endpackage

// File: rtl/rb_field.sv
module rb_field
  import rb_pkg::*;
#(
  parameter int   W       = 4,
  parameter acc_e BUS_POL = ACC_RW,
  parameter acc_e DEV_POL = ACC_RO
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_wmask,
  input  logic [W-1:0] bus_wdata,
  input  logic         dev_we,
  input  logic [W-1:0] dev_wdata,
  output logic [W-1:0] bus_view,
  output logic [W-1:0] dev_view
);
  localparam bit BUS_CAN_W = (BUS_POL != ACC_RO);
  localparam bit DEV_CAN_W = (DEV_POL != ACC_RO);

  logic [W-1:0] val;

  // Device write takes the whole field and wins over any bus write.
  always_ff @(posedge clk) begin
    if (!rst_n)
      val <= '0;
    else if (DEV_CAN_W && dev_we)
      val <= dev_wdata;
    else if (BUS_CAN_W)
      val <= (val & ~bus_wmask) | (bus_wdata & bus_wmask);
  end

  generate
    if (BUS_POL == ACC_WO) begin : g_bus_hide
      assign bus_view = '0;
    end else begin : g_bus_show
      assign bus_view = val;
    end
    if (DEV_POL == ACC_WO) begin : g_dev_hide
      assign dev_view = '0;
    end else begin : g_dev_show
      assign dev_view = val;
    end
  endgenerate
endmodule

// File: rtl/rb_raw_port.sv
module rb_raw_port #(
  parameter int RAW_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_we,
  input  logic [RAW_W-1:0] wdata,
  output logic [RAW_W-1:0] wr_data,
  output logic             wr_stb
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_stb <= hit_we;
      if (hit_we) wr_data <= wdata;
    end
  end
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import rb_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int RAW_W    = 6,
  parameter int MODE_W   = 5,
  parameter int STAT_W   = 4,
  parameter int CMD_W    = 3,
  parameter int RAW_ADDR = 0,
  parameter int REG_BASE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [RAW_W-1:0]  raw_wr_data,
  output logic              raw_wr_stb,
  input  logic [RAW_W-1:0]  raw_rd_val,
  output logic [MODE_W-1:0] mode_q,
  input  logic [STAT_W-1:0] stat_in,
  input  logic              stat_we,
  output logic [CMD_W-1:0]  cmd_q,
  input  logic [CMD_W-1:0]  cmd_in,
  input  logic              cmd_we
);
  localparam int REG_W = MODE_W + STAT_W + CMD_W;
  localparam int NW    = (REG_W + DATA_W - 1) / DATA_W;
  localparam int PAD_W = NW * DATA_W;

  // ---------------- pass-through register ----------------
  logic raw_hit_we;
  assign raw_hit_we = bus_we && (bus_addr == ADDR_W'(RAW_ADDR));

  rb_raw_port #(.RAW_W(RAW_W)) u_raw (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_we  (raw_hit_we),
    .wdata   (bus_wdata[RAW_W-1:0]),
    .wr_data (raw_wr_data),
    .wr_stb  (raw_wr_stb)
  );

  // ---------------- managed register: per-bit write mask ----------------
  // Bit i lives in word (NW-1 - i/DATA_W): the top word has the lowest address.
  logic [REG_W-1:0] wmask;
  logic [REG_W-1:0] wbits;
  generate
    for (genvar i = 0; i < REG_W; i++) begin : g_mask
      localparam int WIDX = NW - 1 - (i / DATA_W);
      assign wmask[i] = bus_we && (bus_addr == ADDR_W'(REG_BASE + WIDX));
      assign wbits[i] = bus_wdata[i % DATA_W];
    end
  endgenerate

  localparam int CMD_LO  = 0;
  localparam int STAT_LO = CMD_W;
  localparam int MODE_LO = CMD_W + STAT_W;

  logic [MODE_W-1:0] mode_bv;
  logic [STAT_W-1:0] stat_bv, stat_dv;
  logic [CMD_W-1:0]  cmd_bv;

  rb_field #(.W(MODE_W), .BUS_POL(ACC_RW), .DEV_POL(ACC_RO)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wmask (wmask[MODE_LO +: MODE_W]),
    .bus_wdata (wbits[MODE_LO +: MODE_W]),
    .dev_we    (1'b0),
    .dev_wdata ('0),
    .bus_view  (mode_bv),
    .dev_view  (mode_q)
  );

  rb_field #(.W(STAT_W), .BUS_POL(ACC_RO), .DEV_POL(ACC_WO)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wmask (wmask[STAT_LO +: STAT_W]),
    .bus_wdata (wbits[STAT_LO +: STAT_W]),
    .dev_we    (stat_we),
    .dev_wdata (stat_in),
    .bus_view  (stat_bv),
    .dev_view  (stat_dv)
  );

  rb_field #(.W(CMD_W), .BUS_POL(ACC_WO), .DEV_POL(ACC_RW)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wmask (wmask[CMD_LO +: CMD_W]),
    .bus_wdata (wbits[CMD_LO +: CMD_W]),
    .dev_we    (cmd_we),
    .dev_wdata (cmd_in),
    .bus_view  (cmd_bv),
    .dev_view  (cmd_q)
  );

  // ---------------- read path ----------------
  logic [PAD_W-1:0]  reg_pad;
  logic [DATA_W-1:0] words [NW];
  assign reg_pad = PAD_W'({mode_bv, stat_bv, cmd_bv});

  generate
    for (genvar k = 0; k < NW; k++) begin : g_word
      assign words[k] = reg_pad[(NW-1-k)*DATA_W +: DATA_W];
    end
  endgenerate

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(RAW_ADDR))
      rd_next = DATA_W'(raw_rd_val);
    for (int k = 0; k < NW; k++)
      if (bus_addr == ADDR_W'(REG_BASE + k))
        rd_next = words[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_next;
  end

  // stat_dv is hidden from the device by policy; kept for structure symmetry.
  logic unused_ok;
  assign unused_ok = ^stat_dv;
endmodule

// File: rtl/reg_bank_chk.sv
module reg_bank_chk #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int RAW_W    = 6,
  parameter int MODE_W   = 5,
  parameter int STAT_W   = 4,
  parameter int CMD_W    = 3,
  parameter int RAW_ADDR = 0,
  parameter int REG_BASE = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [RAW_W-1:0]  raw_wr_data,
  input logic              raw_wr_stb,
  input logic [RAW_W-1:0]  raw_rd_val,
  input logic [MODE_W-1:0] mode_q,
  input logic [STAT_W-1:0] stat_in,
  input logic              stat_we,
  input logic [STAT_W-1:0] stat_val,
  input logic [CMD_W-1:0]  cmd_q,
  input logic [CMD_W-1:0]  cmd_in,
  input logic              cmd_we
);
  localparam int REG_W = MODE_W + STAT_W + CMD_W;
  localparam int NW    = (REG_W + DATA_W - 1) / DATA_W;

  logic raw_w, reg_w, last_w, mapped;
  assign raw_w  = bus_we && (int'(bus_addr) == RAW_ADDR);
  assign reg_w  = bus_we && (int'(bus_addr) >= REG_BASE) && (int'(bus_addr) < REG_BASE + NW);
  assign last_w = bus_we && (int'(bus_addr) == REG_BASE + NW - 1);
  assign mapped = (int'(bus_addr) == RAW_ADDR) ||
                  ((int'(bus_addr) >= REG_BASE) && (int'(bus_addr) < REG_BASE + NW));

  a_r2_stb_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    raw_w |=> (raw_wr_stb && raw_wr_data == $past(bus_wdata[RAW_W-1:0])));

  a_r2_stb_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_w |=> !raw_wr_stb);

  a_r3_raw_read: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr) == RAW_ADDR) |=>
      (bus_rdata[RAW_W-1:0] == $past(raw_rd_val) && (bus_rdata >> RAW_W) == '0));

  a_r5_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_w |=> $stable(mode_q));

  a_r6_stat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_we |=> $stable(stat_val));

  a_r6_stat_load: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> stat_val == $past(stat_in));

  a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_we && !last_w) |=> $stable(cmd_q));

  a_r8_dev_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> cmd_q == $past(cmd_in));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |=> bus_rdata == '0);
endmodule

bind reg_bank reg_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAW_W(RAW_W), .MODE_W(MODE_W),
  .STAT_W(STAT_W), .CMD_W(CMD_W), .RAW_ADDR(RAW_ADDR), .REG_BASE(REG_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .raw_wr_data(raw_wr_data),
  .raw_wr_stb(raw_wr_stb), .raw_rd_val(raw_rd_val), .mode_q(mode_q),
  .stat_in(stat_in), .stat_we(stat_we), .stat_val(stat_bv), .cmd_q(cmd_q),
  .cmd_in(cmd_in), .cmd_we(cmd_we)
);

// File: tb/sim_reg_bank.sv
`timescale 1ns/1ps
module sim_reg_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [5:0] raw_wr_data;
  logic       raw_wr_stb;
  logic [5:0] raw_rd_val = '0;
  logic [4:0] mode_q;
  logic [3:0] stat_in = '0;
  logic       stat_we = 1'b0;
  logic [2:0] cmd_q;
  logic [2:0] cmd_in = '0;
  logic       cmd_we = 1'b0;

  always #5 clk = ~clk;

  reg_bank u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [4:0] m_mode = '0;
  logic [3:0] m_stat = '0;
  logic [2:0] m_cmd  = '0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [3:0] a, input logic [5:0] rv);
    case (a)
      4'd0:    return {2'b00, rv};
      4'd1:    return {4'b0000, m_mode[4:1]};
      4'd2:    return {m_mode[0], m_stat, 3'b000};
      default: return 8'h00;
    endcase
  endfunction

  // One bus cycle plus device activity; checks at the following falling edge.
  task automatic step(input logic [3:0] a, input logic we, input logic [7:0] wd,
                      input logic swe, input logic [3:0] sin,
                      input logic cwe, input logic [2:0] cin,
                      input logic [5:0] rv, input string rtag);
    logic [7:0] e_rd;
    logic       e_stb;
    bit         clash;
    bus_addr = a; bus_we = we; bus_wdata = wd;
    stat_we = swe; stat_in = sin; cmd_we = cwe; cmd_in = cin; raw_rd_val = rv;
    e_rd  = exp_read(a, rv);
    e_stb = we && (a == 4'd0);
    clash = cwe && we && (a == 4'd2);
    if (we && a == 4'd1) m_mode[4:1] = wd[3:0];
    if (we && a == 4'd2) begin m_mode[0] = wd[7]; m_cmd = wd[2:0]; end
    if (swe) m_stat = sin;
    if (cwe) m_cmd = cin;
    @(posedge clk);
    @(negedge clk);
    check(rtag == "" ? (a == 0 ? "R3" : (a <= 2 ? "R4" : "R9")) : rtag,
          "read", bus_rdata, e_rd);
    check("R5", "mode_q", mode_q, m_mode);
    check(clash ? "R8" : "R7", "cmd_q", cmd_q, m_cmd);
    check("R2", "strobe", raw_wr_stb, e_stb);
    if (e_stb) check("R2", "raw data", raw_wr_data, wd[5:0]);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1", "rdata", bus_rdata, 0);
    check("R1", "mode", mode_q, 0);
    check("R1", "cmd", cmd_q, 0);
    check("R1", "strobe", raw_wr_stb, 0);
    step(4'd2, 0, 8'h00, 0, 0, 0, 0, 6'h00, "R1");
    // R2 raw write then silence
    step(4'd0, 1, 8'hFF, 0, 0, 0, 0, 6'h15, "R3");
    step(4'd0, 0, 8'h00, 0, 0, 0, 0, 6'h2A, "R3");
    // R5 mode via both words
    step(4'd1, 1, 8'hFA, 0, 0, 0, 0, 6'h00, "R4");
    step(4'd2, 1, 8'h85, 0, 0, 0, 0, 6'h00, "R7");
    step(4'd1, 0, 8'h00, 0, 0, 0, 0, 6'h00, "R5");
    // R6 bus write to stat ignored, device load seen
    step(4'd2, 1, 8'hF8, 0, 0, 0, 0, 6'h00, "R6");
    step(4'd2, 0, 8'h00, 1, 4'h9, 0, 0, 6'h00, "R6");
    step(4'd2, 0, 8'h00, 0, 0, 0, 0, 6'h00, "R6");
    // R8 collision, device wins
    step(4'd2, 1, 8'h07, 0, 0, 1, 3'h2, 6'h00, "R8");
    // R9 unmapped write, then read it back and neighbours
    step(4'd9, 1, 8'hFF, 0, 0, 0, 0, 6'h00, "R9");
    step(4'd15, 0, 8'h00, 0, 0, 0, 0, 6'h00, "R9");
    // R10 read follows the address of the previous cycle
    step(4'd1, 0, 8'h00, 0, 0, 0, 0, 6'h00, "R10");
    step(4'd2, 0, 8'h00, 0, 0, 0, 0, 6'h00, "R10");
    for (int i = 0; i < 3000; i++) begin
      step(4'($urandom_range(0, 5) == 5 ? $urandom_range(3, 15) : $urandom_range(0, 2)),
           1'($urandom_range(0, 1)), 8'($urandom),
           1'($urandom_range(0, 3) == 0), 4'($urandom),
           1'($urandom_range(0, 3) == 0), 3'($urandom),
           6'($urandom), "");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule